// File: doc/BRIEF.md
# PHY DLL Reset and Lock Sequencer

This block runs the start-up sequence of a memory PHY delay line on the configuration clock. The configuration clock runs at one quarter of the PHY PLL clock. A 32-bit read/write timing register holds three programmable durations: how long the DLL soft reset is held, how long to wait for the DLL to lock, and how long the ITM soft reset is held.

A one-cycle start pulse launches a sequence with three phases. First the DLL soft-reset pin is asserted for its programmed count. Then the lock wait begins, counted from the cycle the DLL reset is released; when it expires the DLL is flagged ready. Last, the ITM soft-reset pin is asserted for its own count. A busy flag covers the whole sequence and a done flag pulses once at its end.

The DLL and ITM are modelled only as reset pins. Nothing senses an actual lock, so the ready flag means only that the programmed wait has elapsed.

Top module: `dll_init_seq`

## Requirements
- R1: After reset the timing register reads 0x0022AF9B. Bits 31:22 always read as zero, and writes to them have no effect.
- R2: The register fields are: DLL reset length in bits 5:0, lock wait in bits 17:6, and ITM reset length in bits 21:18. The reset value decodes to 27, 2750 and 8.
- R3: An accepted start holds `dll_srst_o` high for exactly the DLL reset length, beginning in the cycle after the start is sampled.
- R4: When `dll_srst_o` falls, the lock wait follows: exactly the lock-wait count of cycles in which `busy_o` is high, both reset pins are low and `dll_ready_o` is low.
- R5: `dll_ready_o` rises in the first cycle after the lock wait. It stays high through the ITM phase and while idle, until the next accepted start clears it.
- R6: `itm_srst_o` is high for exactly the ITM reset length, directly after the lock wait. The two reset pins are never high together.
- R7: `busy_o` is high from the first DLL reset cycle through the last ITM reset cycle. `done_o` is high for exactly one cycle after that, with `busy_o` low.
- R8: A programmed length of zero in any field gives a phase of one cycle.
- R9: A start sampled while `busy_o` is high is ignored, including one sampled in the last ITM cycle.
- R10: All three lengths are captured when a start is accepted. A write in the same cycle as the start, or during a sequence, takes effect only at the next start.
- R11: A start sampled in the cycle `done_o` is high is accepted and begins a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Timing register write enable |
| cfg_wdata_i | input | 32 | Timing register write data |
| cfg_rdata_o | output | 32 | Timing register read data |
| start_i | input | 1 | Single-cycle start of a sequence |
| dll_srst_o | output | 1 | DLL soft-reset pin, active high |
| itm_srst_o | output | 1 | ITM soft-reset pin, active high |
| dll_ready_o | output | 1 | Lock wait has elapsed |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a register write and a start. The bench writes new lengths in the same cycle as a start, and again in the middle of a sequence. It judges the result by measuring every phase length against the old values, and then reading back the new value.

The second pair is the end of a sequence and a new start. The bench drives a start in the cycle `done_o` is high, and it must be accepted. It also drives a start in the last ITM cycle, which must be ignored. The first case is judged by a new DLL reset phase of the right length, and the second by `busy_o` staying low after the done pulse.

// File: rtl/dll_seq_pkg.sv
package dll_seq_pkg;
  localparam int REG_W   = 32;
  localparam int DRST_W  = 6;
  localparam int LOCK_W  = 12;
  localparam int ITM_W   = 4;
  localparam int TIMES_W = DRST_W + LOCK_W + ITM_W;
  localparam int CNT_W   = LOCK_W;
  localparam logic [REG_W-1:0] REG_RST = 32'h0022_AF9B;

  // packed order matches register layout: drst at lsb
  typedef struct packed {
    logic [ITM_W-1:0]  itm;
    logic [LOCK_W-1:0] lock;
    logic [DRST_W-1:0] drst;
  } seq_times_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DRST = 2'd1,
    ST_LOCK = 2'd2,
    ST_ITM  = 2'd3
  } seq_state_e;

  // length-1 with zero clamped to one cycle
  function automatic logic [CNT_W-1:0] len_to_load(input logic [CNT_W-1:0] len);
    return (len == '0) ? '0 : len - 1'b1;
  endfunction
endpackage

// File: rtl/dll_seq_timing_reg.sv
module dll_seq_timing_reg
  import dll_seq_pkg::*;
#(
  parameter int                REG_WIDTH = REG_W,
  parameter logic [REG_W-1:0]  RST_VAL   = REG_RST
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [REG_WIDTH-1:0] wdata_i,
  output logic [REG_WIDTH-1:0] rdata_o,
  output seq_times_t           times_o
);
  localparam int PAD_W = REG_WIDTH - TIMES_W;

  seq_times_t times_q;
  logic [PAD_W-1:0] unused_hi;

  assign unused_hi = wdata_i[REG_WIDTH-1:TIMES_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      times_q <= seq_times_t'(RST_VAL[TIMES_W-1:0]);
    end else if (we_i) begin
      times_q <= seq_times_t'(wdata_i[TIMES_W-1:0]);
    end
  end

  assign times_o = times_q;
  assign rdata_o = {{PAD_W{1'b0}}, times_q};
endmodule

// File: rtl/dll_seq_counter.sv
module dll_seq_counter #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dll_seq_ctrl.sv
module dll_seq_ctrl
  import dll_seq_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  seq_times_t    times_i,
  input  logic          cnt_zero_i,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic          dll_srst_o,
  output logic          itm_srst_o,
  output logic          dll_ready_o,
  output logic          busy_o,
  output logic          done_o
);
  seq_state_e        state_q, state_d;
  logic [LOCK_W-1:0] lock_snap_q;
  logic [ITM_W-1:0]  itm_snap_q;
  logic              ready_q, done_q;
  logic              accept;

  assign accept = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d    = ST_DRST;
        load_o     = 1'b1;
        load_val_o = len_to_load(CW'(times_i.drst));
      end
      ST_DRST: if (cnt_zero_i) begin
        state_d    = ST_LOCK;
        load_o     = 1'b1;
        load_val_o = len_to_load(CW'(lock_snap_q));
      end
      ST_LOCK: if (cnt_zero_i) begin
        state_d    = ST_ITM;
        load_o     = 1'b1;
        load_val_o = len_to_load(CW'(itm_snap_q));
      end
      ST_ITM: if (cnt_zero_i) begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      lock_snap_q <= '0;
      itm_snap_q  <= '0;
      ready_q     <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_ITM) && cnt_zero_i;
      if (accept) begin
        lock_snap_q <= times_i.lock;
        itm_snap_q  <= times_i.itm;
      end
      if (accept) begin
        ready_q <= 1'b0;
      end else if ((state_q == ST_LOCK) && cnt_zero_i) begin
        ready_q <= 1'b1;
      end
    end
  end

  assign dll_srst_o  = (state_q == ST_DRST);
  assign itm_srst_o  = (state_q == ST_ITM);
  assign busy_o      = (state_q != ST_IDLE);
  assign dll_ready_o = ready_q;
  assign done_o      = done_q;
endmodule

// File: rtl/dll_init_seq.sv
module dll_init_seq
  import dll_seq_pkg::*;
#(
  parameter int DATA_W = REG_W,
  parameter int CW     = CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic              start_i,
  output logic              dll_srst_o,
  output logic              itm_srst_o,
  output logic              dll_ready_o,
  output logic              busy_o,
  output logic              done_o
);
  seq_times_t    times;
  logic          cnt_load, cnt_zero;
  logic [CW-1:0] cnt_load_val;

  dll_seq_timing_reg #(.REG_WIDTH(DATA_W), .RST_VAL(REG_RST)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .times_o (times)
  );

  dll_seq_counter #(.W(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_load_val),
    .zero_o     (cnt_zero)
  );

  dll_seq_ctrl #(.CW(CW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .times_i     (times),
    .cnt_zero_i  (cnt_zero),
    .load_o      (cnt_load),
    .load_val_o  (cnt_load_val),
    .dll_srst_o  (dll_srst_o),
    .itm_srst_o  (itm_srst_o),
    .dll_ready_o (dll_ready_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );
endmodule

// File: rtl/dll_init_seq_chk.sv
module dll_init_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic dll_srst_o,
  input logic itm_srst_o,
  input logic dll_ready_o,
  input logic busy_o,
  input logic done_o
);
  AST_PINS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dll_srst_o && itm_srst_o)); // R6

  AST_START_ENTERS_DRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (dll_srst_o && !dll_ready_o)); // R3

  AST_LOCK_AFTER_DRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dll_srst_o) |-> (busy_o && !itm_srst_o && !dll_ready_o)); // R4

  AST_READY_AT_ITM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dll_ready_o) |-> itm_srst_o); // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7

  AST_DONE_AFTER_ITM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(itm_srst_o))); // R7

  AST_PIN_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dll_srst_o || itm_srst_o) |-> busy_o); // R7

  AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !itm_srst_o) |=> busy_o); // R9
endmodule

bind dll_init_seq dll_init_seq_chk u_chk (.*);

// File: tb/dll_init_seq_bench.sv
`timescale 1ns/1ps
module dll_init_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        start_i = 1'b0;
  logic        dll_srst_o, itm_srst_o, dll_ready_o, busy_o, done_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  dll_init_seq u_dll_init_seq (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_wdata_i, .cfg_rdata_o,
    .start_i, .dll_srst_o, .itm_srst_o, .dll_ready_o, .busy_o, .done_o
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic logic [31:0] pack(input int d, input int l, input int i);
    return {10'b0, 4'(i), 12'(l), 6'(d)};
  endfunction

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic write_reg(input logic [31:0] v);
    cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  // start pulse, optionally with a write on the same edge
  task automatic launch(input bit with_wr, input logic [31:0] v);
    start_i = 1'b1;
    if (with_wr) begin cfg_we_i = 1'b1; cfg_wdata_i = v; end
    @(negedge clk_i);
    start_i = 1'b0; cfg_we_i = 1'b0;
  endtask

  // observe from the first sequence cycle until done is seen; poke_at >= 0 drives
  // start plus a write of poke_val during that observed cycle
  task automatic measure(input int d, input int l, input int i, input string tag,
                         input int poke_at, input logic [31:0] poke_val);
    int nd = 0, nl = 0, ni = 0, phase = 0, order_err = 0, it = 0;
    while (!done_o && it < 10000) begin
      if (dll_srst_o) begin
        nd++;
        if (dll_ready_o || itm_srst_o || phase != 0) order_err++;
      end else if (itm_srst_o) begin
        ni++; phase = 2;
        if (!dll_ready_o) order_err++;
      end else if (busy_o) begin
        nl++;
        if (phase == 2 || dll_ready_o) order_err++;
        phase = 1;
      end else begin
        order_err++;
      end
      if (it == poke_at) begin
        start_i = 1'b1; cfg_we_i = 1'b1; cfg_wdata_i = poke_val;
      end
      @(negedge clk_i);
      start_i = 1'b0; cfg_we_i = 1'b0;
      it++;
    end
    chk(nd == eff(d), {"R3/R8 dll reset length ", tag}, nd, eff(d));
    chk(nl == eff(l), {"R4/R8 lock wait length ", tag}, nl, eff(l));
    chk(ni == eff(i), {"R6/R8 itm reset length ", tag}, ni, eff(i));
    chk(order_err == 0, {"R4 R5 R6 phase order ", tag}, order_err, 0);
    chk(done_o && !busy_o && dll_ready_o, {"R7 done pulse ", tag},
        {done_o, busy_o, dll_ready_o}, 3'b101);
  endtask

  task automatic after_done(input string tag);
    @(negedge clk_i);
    chk(!done_o && !busy_o, {"R7/R9 done one cycle, idle ", tag}, {done_o, busy_o}, 0);
  endtask

  initial begin
    #(100000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(cfg_rdata_o == 32'h0022AF9B, "R1 reset value", cfg_rdata_o, 32'h0022AF9B);
    chk({dll_srst_o, itm_srst_o, dll_ready_o, busy_o, done_o} == 0, "R7 outputs low in reset",
        {dll_srst_o, itm_srst_o, dll_ready_o, busy_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 reset decode 27 / 2750 / 8
    launch(1'b0, '0);
    measure(27, 2750, 8, "R2 reset fields", -1, '0);
    after_done("R2");
    // R5 ready holds while idle
    repeat (3) @(negedge clk_i);
    chk(dll_ready_o, "R5 ready holds while idle", dll_ready_o, 1);

    // R1 upper bits ignored
    write_reg(32'hFFFF_FFFF);
    chk(cfg_rdata_o == 32'h003F_FFFF, "R1 upper bits read zero", cfg_rdata_o, 32'h003F_FFFF);

    // near-exhaustive small sweep, R2 R3 R4 R6 R8
    for (int d = 0; d < 6; d++)
      for (int l = 0; l < 5; l++)
        for (int i = 0; i < 4; i++) begin
          write_reg(pack(d, l, i));
          chk(cfg_rdata_o == pack(d, l, i), "R2 field readback", cfg_rdata_o, pack(d, l, i));
          launch(1'b0, '0);
          measure(d, l, i, $sformatf("sweep d%0d l%0d i%0d", d, l, i), -1, '0);
          after_done("sweep");
        end

    // maximum fields
    write_reg(pack(63, 4095, 15));
    launch(1'b0, '0);
    measure(63, 4095, 15, "R2 max fields", -1, '0);
    after_done("max");

    // R10 write on same edge as start uses old values
    write_reg(pack(3, 2, 2));
    launch(1'b1, pack(5, 4, 1));
    measure(3, 2, 2, "R10 same-edge write", -1, '0);
    chk(cfg_rdata_o == pack(5, 4, 1), "R10 same-edge write lands", cfg_rdata_o, pack(5, 4, 1));
    after_done("R10a");

    // R9 R10 start+write during DLL reset ignored by running sequence
    launch(1'b0, '0);
    measure(5, 4, 1, "R9 start in drst", 1, pack(2, 3, 4));
    after_done("R9a");
    chk(cfg_rdata_o == pack(2, 3, 4), "R10 mid-sequence write lands", cfg_rdata_o, pack(2, 3, 4));

    // R9 start in the last ITM cycle ignored
    launch(1'b0, '0);
    measure(2, 3, 4, "R9 start in last itm", 1 + 3 + 4 - 1 + 1, pack(2, 3, 4));
    after_done("R9b");

    // R11 start in the done cycle, new values from write during sequence
    write_reg(pack(1, 1, 1));
    launch(1'b0, '0);
    measure(1, 1, 1, "R11 first", -1, '0);
    write_reg(pack(4, 0, 2));
    launch(1'b0, '0);
    measure(4, 0, 2, "R11 chained setup", -1, '0);
    // done is high now: start in this cycle
    launch(1'b0, '0);
    chk(dll_srst_o && busy_o && !dll_ready_o, "R11 start on done accepted",
        {dll_srst_o, busy_o, dll_ready_o}, 3'b110);
    measure(4, 0, 2, "R11 chained", -1, '0);
    after_done("R11");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule